// File: doc/BRIEF.md
# GPIO Pin Register Bank

A bank of 32 general-purpose pins controlled through a single-cycle, 32-bit register bus. Each pin has a direction bit and an output data bit. It also has an input path that is resynchronized to the bus clock. The pad buffer is shown as two separate vectors, an output enable and an output data, so the pad ring can instantiate its own tristate cells.

Direction never needs a read-modify-write. One register turns the selected pins into outputs and a second turns them into inputs, and that second register also reads back the current direction. Output levels are written per half-bank. Each half-bank register carries a 16-bit write mask alongside the 16 values, so a single pin can be changed on its own without disturbing the others. Firmware is expected to load a pin's output level while the pin is still an input and then switch its direction, so the output level is stored independently of direction.

Top module: `gpio_bank`

## Requirements
- R1: After reset, `pin_oe_o` and `pin_out_o` are all zero, and reads of offsets 0x04, 0x08 and 0x0C return zero.
- R2: A write to offset 0x00 sets each direction bit whose data bit is 1, which makes that pin an output (`pin_oe_o` bit = 1) from the next clock. Direction bits whose data bit is 0 are left unchanged.
- R3: A write to offset 0x04 clears each direction bit whose data bit is 1, which makes that pin an input from the next clock. Direction bits whose data bit is 0 are left unchanged.
- R4: A read of offset 0x04 returns the direction of all 32 pins, with bit n = 1 meaning pin n is an output. Offset 0x00 is write-only and reads as zero.
- R5: A write to offset 0x08 updates output data for pins 0..15. Data bit n (n in 0..15) becomes the level of pin n only when data bit n+16 (the mask bit) is 1. Pins whose mask bit is 0 keep their level.
- R6: A write to offset 0x0C does the same for pins 16..31. Data bit n (n in 0..15) is the level of pin n+16, and data bit n+16 is its mask bit.
- R7: Output data is stored regardless of direction. `pin_out_o` shows the stored levels for input pins as well, and direction writes never alter them.
- R8: A read of offset 0x08 or 0x0C returns the 16 stored levels of that half in bits 15:0 and zero in bits 31:16.
- R9: A read of offset 0x10 returns the pin inputs through a two-flop synchronizer. A level applied before a clock edge appears on the read after the second edge, and not after the first.
- R10: Reads at any other offset return zero, and writes to any other offset change no state. Reads and writes complete in the cycle they are presented, and reads have no side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and pin clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_addr_i | input | 8 | Byte offset of the access |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| pin_in_i | input | 32 | Pad input levels, asynchronous |
| pin_oe_o | output | 32 | Pad output enable, 1 = drive |
| pin_out_o | output | 32 | Pad output level |

## Verification
The first test walks a single one through every pin, first via the set register and then via the clear register. This shows that each direction bit is addressed on its own and that zero bits hold their state. A long pseudo-random stream of set, clear, masked half-bank writes and unmapped writes is then checked against a bench model after every write. Random masks separate a correct per-bit mask from a half-wide or inverted one, and the mixing shows that direction writes leave output data alone. Finally, input patterns are sampled one and two clocks after they change, which separates a two-stage synchronizer from a shorter or longer one.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned DATA_W = 32;

  localparam logic [7:0] OFS_DIR_SET = 8'h00;
  localparam logic [7:0] OFS_DIR_CLR = 8'h04;
  localparam logic [7:0] OFS_OUT_LO  = 8'h08;
  localparam logic [7:0] OFS_OUT_HI  = 8'h0C;
  localparam logic [7:0] OFS_PIN_IN  = 8'h10;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DIR_SET,
    SEL_DIR_CLR,
    SEL_OUT_LO,
    SEL_OUT_HI,
    SEL_PIN_IN
  } reg_sel_e;
endpackage

// File: rtl/gpio_bank_decode.sv
module gpio_bank_decode
  import gpio_bank_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);
  always_comb begin
    sel_o = SEL_NONE;
    if (addr_i == ADDR_W'(OFS_DIR_SET))      sel_o = SEL_DIR_SET;
    else if (addr_i == ADDR_W'(OFS_DIR_CLR)) sel_o = SEL_DIR_CLR;
    else if (addr_i == ADDR_W'(OFS_OUT_LO))  sel_o = SEL_OUT_LO;
    else if (addr_i == ADDR_W'(OFS_OUT_HI))  sel_o = SEL_OUT_HI;
    else if (addr_i == ADDR_W'(OFS_PIN_IN))  sel_o = SEL_PIN_IN;
  end
endmodule

// File: rtl/gpio_dir_reg.sv
module gpio_dir_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] bits_i,
  output logic [W-1:0] dir_o
);
  logic [W-1:0] dir_q, dir_d;

  always_comb begin
    dir_d = dir_q;
    if (set_i) dir_d = dir_d | bits_i;
    if (clr_i) dir_d = dir_d & ~bits_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dir_q <= '0;
    else         dir_q <= dir_d;
  end

  assign dir_o = dir_q;

  AST_DIR_SET_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !clr_i) |=> ((dir_q & $past(bits_i)) == $past(bits_i))); // R2
  AST_DIR_SET_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !clr_i) |=> (((dir_q ^ $past(dir_q)) & ~$past(bits_i)) == '0)); // R2
  AST_DIR_CLR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> ((dir_q & $past(bits_i)) == '0)); // R3
  AST_DIR_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(dir_q)); // R10
endmodule

// File: rtl/gpio_out_half.sv
module gpio_out_half #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] val_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_q <= '0;
    else if (we_i) q_q <= (q_q & ~mask_i) | (val_i & mask_i);
  end

  assign q_o = q_q;

  AST_MASK_GUARDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (((q_q ^ $past(q_q)) & ~$past(mask_i)) == '0)); // R5
  AST_MASK_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ((q_q & $past(mask_i)) == ($past(val_i) & $past(mask_i)))); // R6
  AST_OUT_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_q)); // R7
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] pin_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < STAGES; k++) stg_q[k] <= '0;
    end else begin
      stg_q[0] <= pin_i;
      for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
    end
  end

  assign pin_o = stg_q[STAGES-1];

  AST_SYNC_SHIFTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(pin_i) |=> (stg_q[0] == $past(pin_i))); // R9
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned NUM_PINS    = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic                bus_wr_i,
  input  logic [DATA_W-1:0]   bus_wdata_i,
  output logic [DATA_W-1:0]   bus_rdata_o,
  input  logic [NUM_PINS-1:0] pin_in_i,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic [NUM_PINS-1:0] pin_out_o
);
  localparam int unsigned HALF = NUM_PINS / 2;

  reg_sel_e            sel;
  logic [NUM_PINS-1:0] dir_q, out_q, in_sync;

  gpio_bank_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (bus_addr_i),
    .sel_o  (sel)
  );

  gpio_dir_reg #(.W(NUM_PINS)) u_dir (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (bus_wr_i && sel == SEL_DIR_SET),
    .clr_i  (bus_wr_i && sel == SEL_DIR_CLR),
    .bits_i (bus_wdata_i[NUM_PINS-1:0]),
    .dir_o  (dir_q)
  );

  for (genvar h = 0; h < 2; h++) begin : g_half
    localparam reg_sel_e HSEL = (h == 0) ? SEL_OUT_LO : SEL_OUT_HI;
    gpio_out_half #(.W(HALF)) u_half (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (bus_wr_i && sel == HSEL),
      .mask_i (bus_wdata_i[DATA_W-1 -: HALF]),
      .val_i  (bus_wdata_i[HALF-1:0]),
      .q_o    (out_q[h*HALF +: HALF])
    );
  end

  gpio_in_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_in_i),
    .pin_o  (in_sync)
  );

  always_comb begin
    bus_rdata_o = '0;
    unique case (sel)
      SEL_DIR_CLR: bus_rdata_o = DATA_W'(dir_q);
      SEL_OUT_LO:  bus_rdata_o = DATA_W'(out_q[HALF-1:0]);
      SEL_OUT_HI:  bus_rdata_o = DATA_W'(out_q[NUM_PINS-1:HALF]);
      SEL_PIN_IN:  bus_rdata_o = DATA_W'(in_sync);
      default:     bus_rdata_o = '0;
    endcase
  end

  assign pin_oe_o  = dir_q;
  assign pin_out_o = out_q;

  AST_RD_DIR_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == SEL_DIR_CLR) |-> (bus_rdata_o == DATA_W'(pin_oe_o))); // R4
  AST_RD_OUT_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == SEL_OUT_LO || sel == SEL_OUT_HI) |-> (bus_rdata_o[DATA_W-1:HALF] == '0)); // R8
  AST_RD_UNMAPPED:  assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == SEL_NONE || sel == SEL_DIR_SET) |-> (bus_rdata_o == '0)); // R10
  AST_DIR_KEEPS_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && (sel == SEL_DIR_SET || sel == SEL_DIR_CLR)) |=> $stable(pin_out_o)); // R7
endmodule

// File: tb/gpio_bank_test.sv
module gpio_bank_test;
  localparam int unsigned CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_oe, pin_out;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [31:0] m_oe = '0;
  logic [31:0] m_out = '0;
  logic [31:0] rng = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_bank uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .bus_addr_i  (addr),
    .bus_wr_i    (wr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .pin_in_i    (pin_in),
    .pin_oe_o    (pin_oe),
    .pin_out_o   (pin_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; addr = 8'hFC; wdata = '0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
    addr = 8'hFC;
  endtask

  function automatic logic [31:0] next_rng(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  task automatic check_all(input string tag);
    logic [31:0] d;
    chk({tag, " R2 pin_oe"}, pin_oe, m_oe);
    chk({tag, " R7 pin_out"}, pin_out, m_out);
    bus_read(8'h04, d); chk({tag, " R4 dir read"}, d, m_oe);
    bus_read(8'h00, d); chk({tag, " R4 set reg reads zero"}, d, 32'h0);
    bus_read(8'h08, d); chk({tag, " R8 lo read"}, d, {16'h0, m_out[15:0]});
    bus_read(8'h0C, d); chk({tag, " R8 hi read"}, d, {16'h0, m_out[31:16]});
    bus_read(8'h14, d); chk({tag, " R10 unmapped"}, d, 32'h0);
    bus_read(8'h09, d); chk({tag, " R10 unaligned"}, d, 32'h0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] d;
    addr = 8'hFC;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 oe", pin_oe, 32'h0);
    chk("R1 out", pin_out, 32'h0);
    bus_read(8'h04, d); chk("R1 dir", d, 32'h0);
    bus_read(8'h08, d); chk("R1 lo", d, 32'h0);
    bus_read(8'h0C, d); chk("R1 hi", d, 32'h0);

    // R2 walking set
    for (int i = 0; i < 32; i++) begin
      bus_write(8'h00, 32'h1 << i);
      m_oe |= 32'h1 << i;
      chk("R2 walk set", pin_oe, m_oe);
    end
    // R3 walking clear
    for (int i = 0; i < 32; i++) begin
      bus_write(8'h04, 32'h1 << i);
      m_oe &= ~(32'h1 << i);
      chk("R3 walk clear", pin_oe, m_oe);
      bus_read(8'h04, d); chk("R4 walk read", d, m_oe);
    end

    // R5 R6 walking single-pin output writes
    for (int i = 0; i < 16; i++) begin
      bus_write(8'h08, (32'h1 << (i + 16)) | 32'h0000_FFFF);
      m_out[i] = 1'b1;
      chk("R5 single pin lo", pin_out, m_out);
      bus_write(8'h0C, (32'h1 << (i + 16)) | 32'h0000_FFFF);
      m_out[i+16] = 1'b1;
      chk("R6 single pin hi", pin_out, m_out);
    end

    // mixed random stream
    for (int n = 0; n < 400; n++) begin
      logic [31:0] r;
      rng = next_rng(rng); r = rng;
      rng = next_rng(rng);
      case (r[2:0])
        3'd0, 3'd1: begin bus_write(8'h00, rng); m_oe |= rng; end
        3'd2:       begin bus_write(8'h04, rng); m_oe &= ~rng; end
        3'd3, 3'd4: begin
          bus_write(8'h08, rng);
          m_out[15:0] = (m_out[15:0] & ~rng[31:16]) | (rng[15:0] & rng[31:16]);
        end
        3'd5, 3'd6: begin
          bus_write(8'h0C, rng);
          m_out[31:16] = (m_out[31:16] & ~rng[31:16]) | (rng[15:0] & rng[31:16]);
        end
        default: bus_write({r[7:5], 5'h14} | 8'h14, rng); // R10 unmapped write
      endcase
      check_all("rand");
    end

    // R9 synchronizer latency
    for (int n = 0; n < 64; n++) begin
      logic [31:0] prev;
      prev = pin_in;
      rng = next_rng(rng);
      @(negedge clk);
      pin_in = rng;
      @(negedge clk);
      bus_read(8'h10, d); chk("R9 after one edge", d, prev);
      @(negedge clk);
      bus_read(8'h10, d); chk("R9 after two edges", d, rng);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule